// File: doc/BRIEF.md
# Privileged Link Register Access Router

This block holds two 64-bit return-address registers, one for privilege level 1 and one for privilege level 2. It takes a system-register move request, either a read or a write, described by five encoding fields. The request is qualified by the requester's current privilege level and by the virtualization controls. The block decides where the request goes. It can reach the level-1 register or the level-2 register, be redirected to a fixed memory offset, trap to level 2 with a syndrome class, or be reported as undefined.

The virtualization controls are these six inputs:
- a host-mode bit
- three nesting bits, named `nest_virt`, `nest_el1` and `nest_mem`
- a level-2-enabled flag
- a level-2-runs-64-bit flag

Exception entry writes a return address straight into either register. An exception return from level 1 invalidates the level-1 register.

Unknown register contents are represented by a poison pattern together with a cleared per-register known flag. A read returns this flag with the data, so software-visible garbage can be told apart from a real address.

Top module: `lr_access_router`

## Requirements
- R1: Response timing and code. `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. `rsp_outcome` is one-hot while `rsp_valid` is high and zero otherwise. Bit 4 means undefined, bit 3 trap, bit 2 memory redirect, bit 1 level-1 register and bit 0 level-2 register.
- R2: Encoding match. A request is decoded only when `req_op0`=2'b11, `req_crn`=4'b0100, `req_crm`=4'b0000, `req_op2`=3'b001, and `req_op1` is one of three views: 3'b000 (level-1 view), 3'b101 (alias view) or 3'b100 (level-2 view). Every other encoding is undefined.
- R3: Any request from level 0 (`cur_level`=0) is undefined.
- R4: Level-1 view from level 1, checked in this order:
  - Enabled with `nest_mem`=0 and `nest_el1`=1: trap.
  - Enabled, 64-bit, and all three nesting bits set: memory redirect.
  - Otherwise: level-1 register.
- R5: Level-1 view from level 2 reaches the level-2 register when host mode is 1, and the level-1 register when it is 0. From level 3 it always reaches the level-1 register.
- R6: Alias view from level 1, checked in this order:
  - Enabled with `nest_mem`=1, `nest_el1`=0 and `nest_virt`=1: memory redirect.
  - Enabled with `nest_virt`=1: trap.
  - Otherwise: undefined.
- R7: Alias view from level 2 or 3 reaches the level-1 register only when enabled with host mode 1. Otherwise it is undefined.
- R8: Level-2 view from level 1, checked in this order:
  - Enabled with `nest_mem`=1 and `nest_virt`=1: level-1 register.
  - Enabled with `nest_virt`=1: trap.
  - Otherwise: undefined.
  From level 2 or 3 this view reaches the level-2 register.
- R9: Read data and writes.
  - A register outcome returns that register's value from before the request edge, together with its known flag.
  - A write whose outcome is a register stores `req_wdata` and marks the register known.
  - Any other outcome changes no register and returns zero data.
- R10: `rsp_mem_offset` is 0x230 on a memory redirect and zero otherwise. `rsp_syndrome` is 0x18 on a trap and zero otherwise.
- R11: After reset:
  - `rsp_valid` is 0.
  - Both registers hold 0xDEADDEADDEADDEAD with their known flags cleared.
- R12: `exc_entry_valid` writes `exc_entry_addr` into the level-1 register (`exc_entry_sel`=0) or the level-2 register (`exc_entry_sel`=1) and marks it known. It beats a software write and an exception return to the same register in the same cycle.
- R13: `exc_return_l1` loads the poison pattern into the level-1 register and clears its known flag. It beats a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 (view select) |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Requester privilege level 0..3 |
| lvl2_en | input | 1 | Level 2 enabled |
| lvl2_wide | input | 1 | Level 2 runs 64-bit |
| host_mode | input | 1 | Host mode control |
| nest_virt | input | 1 | Nesting control, base bit |
| nest_el1 | input | 1 | Nesting control, level-1 bit |
| nest_mem | input | 1 | Nesting control, memory bit |
| exc_entry_valid | input | 1 | Exception entry strobe |
| exc_entry_sel | input | 1 | 0 = level-1 register, 1 = level-2 register |
| exc_entry_addr | input | 64 | Return address written on entry |
| exc_return_l1 | input | 1 | Exception return from level 1 |
| rsp_valid | output | 1 | Response strobe |
| rsp_outcome | output | 5 | One-hot outcome code |
| rsp_rdata | output | 64 | Read data |
| rsp_rdata_known | output | 1 | Read data is defined |
| rsp_mem_offset | output | 12 | Redirect offset |
| rsp_syndrome | output | 6 | Trap syndrome class |

## Verification
The assertions check the following on every cycle:
- the one-cycle response strobe and the one-hot outcome code;
- undefined for level-0 requests;
- the redirect offset and syndrome sidebands;
- zero data on non-register outcomes;
- the register contents after exception entry and exception return.

Only the bench's reference model and scenarios can show the rest:
- the full routing table across levels, views and control combinations;
- the order of the priority chains;
- read-before-write data at the request edge;
- the precedence between software writes, exception entry and exception return in the same cycle.

// File: rtl/lr_access_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the link register access router.
// Assumes two link registers: index 0 for level 1, index 1 for level 2.
package lr_access_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_L1    = 2'd1,
        VIEW_ALIAS = 2'd2,
        VIEW_L2    = 2'd3
    } view_e;

    typedef struct packed {
        logic lvl2_en;
        logic lvl2_wide;
        logic host_mode;
        logic nest_virt;
        logic nest_el1;
        logic nest_mem;
    } virt_ctrl_t;

    localparam int OUTC_W   = 5;
    localparam int OC_UNDEF = 4;
    localparam int OC_TRAP  = 3;
    localparam int OC_MEM   = 2;
    localparam int OC_REG1  = 1;
    localparam int OC_REG2  = 0;

    localparam int NUM_LR = 2;
    localparam int LR_L1  = 0;
    localparam int LR_L2  = 1;

endpackage

// File: rtl/lr_encoding_decode.sv
`timescale 1ns/1ps
// Encoding decoder: maps the five move-request fields to a register view.
// Assumes the fixed fields must all match; any mismatch yields VIEW_NONE.
module lr_encoding_decode
    import lr_access_pkg::*;
#(
    parameter logic [1:0] OP0_MATCH   = 2'b11,
    parameter logic [3:0] CRN_MATCH   = 4'b0100,
    parameter logic [3:0] CRM_MATCH   = 4'b0000,
    parameter logic [2:0] OP2_MATCH   = 3'b001,
    parameter logic [2:0] OP1_L1      = 3'b000,
    parameter logic [2:0] OP1_ALIAS   = 3'b101,
    parameter logic [2:0] OP1_L2      = 3'b100
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output view_e      view
);

    logic fixed_ok;

    // Compare the invariant fields.
    always_comb begin
        fixed_ok = (op0 == OP0_MATCH) && (crn == CRN_MATCH) &&
                   (crm == CRM_MATCH) && (op2 == OP2_MATCH);
    end

    // Select the view from op1 when the fixed fields match.
    always_comb begin
        view = VIEW_NONE;
        if (fixed_ok) begin
            if (op1 == OP1_L1)
                view = VIEW_L1;
            else if (op1 == OP1_ALIAS)
                view = VIEW_ALIAS;
            else if (op1 == OP1_L2)
                view = VIEW_L2;
        end
    end

endmodule

// File: rtl/lr_route_policy.sv
`timescale 1ns/1ps
// Routing policy: picks the one-hot outcome for a decoded view at the
// requester's level under the virtualization controls.
// Assumes purely combinational use; the top registers the result.
module lr_route_policy
    import lr_access_pkg::*;
(
    input  level_e            level,
    input  view_e             view,
    input  virt_ctrl_t        ctrl,
    output logic [OUTC_W-1:0] outcome
);

    logic all_nest;
    logic alias_mem;
    logic l1_trap;

    // Precompute the control combinations the priority chains test.
    always_comb begin
        all_nest  = ctrl.nest_mem & ctrl.nest_el1 & ctrl.nest_virt;
        alias_mem = ctrl.nest_mem & ~ctrl.nest_el1 & ctrl.nest_virt;
        l1_trap   = ~ctrl.nest_mem & ctrl.nest_el1;
    end

    // Priority chains per view and level.
    always_comb begin
        outcome = '0;
        outcome[OC_UNDEF] = 1'b1;
        if (view != VIEW_NONE && level != LVL0) begin
            outcome = '0;
            unique case (view)
                VIEW_L1: begin
                    if (level == LVL1) begin
                        if (ctrl.lvl2_en && l1_trap)
                            outcome[OC_TRAP] = 1'b1;
                        else if (ctrl.lvl2_en && ctrl.lvl2_wide && all_nest)
                            outcome[OC_MEM] = 1'b1;
                        else
                            outcome[OC_REG1] = 1'b1;
                    end else if (level == LVL2 && ctrl.host_mode) begin
                        outcome[OC_REG2] = 1'b1;
                    end else begin
                        outcome[OC_REG1] = 1'b1;
                    end
                end
                VIEW_ALIAS: begin
                    if (level == LVL1) begin
                        if (ctrl.lvl2_en && alias_mem)
                            outcome[OC_MEM] = 1'b1;
                        else if (ctrl.lvl2_en && ctrl.nest_virt)
                            outcome[OC_TRAP] = 1'b1;
                        else
                            outcome[OC_UNDEF] = 1'b1;
                    end else if (ctrl.lvl2_en && ctrl.host_mode) begin
                        outcome[OC_REG1] = 1'b1;
                    end else begin
                        outcome[OC_UNDEF] = 1'b1;
                    end
                end
                VIEW_L2: begin
                    if (level == LVL1) begin
                        if (ctrl.lvl2_en && ctrl.nest_mem && ctrl.nest_virt)
                            outcome[OC_REG1] = 1'b1;
                        else if (ctrl.lvl2_en && ctrl.nest_virt)
                            outcome[OC_TRAP] = 1'b1;
                        else
                            outcome[OC_UNDEF] = 1'b1;
                    end else begin
                        outcome[OC_REG2] = 1'b1;
                    end
                end
                default: outcome[OC_UNDEF] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lr_link_regs.sv
`timescale 1ns/1ps
// Link register storage: NUM_REGS return-address registers with known flags.
// Update precedence per register: exception entry, then invalidate, then
// software write. Reset loads the poison pattern and clears the known flags.
module lr_link_regs #(
    parameter int               DATA_W   = 64,
    parameter int               NUM_REGS = 2,
    parameter logic [DATA_W-1:0] POISON  = 64'hDEAD_DEAD_DEAD_DEAD
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              sw_we,
    input  logic [DATA_W-1:0]                sw_wdata,
    input  logic [NUM_REGS-1:0]              ent_we,
    input  logic [DATA_W-1:0]                ent_addr,
    input  logic [NUM_REGS-1:0]              kill,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  val,
    output logic [NUM_REGS-1:0]              known
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Update one register under the fixed precedence.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val[i]   <= POISON;
                known[i] <= 1'b0;
            end else if (ent_we[i]) begin
                val[i]   <= ent_addr;
                known[i] <= 1'b1;
            end else if (kill[i]) begin
                val[i]   <= POISON;
                known[i] <= 1'b0;
            end else if (sw_we[i]) begin
                val[i]   <= sw_wdata;
                known[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lr_access_router.sv
`timescale 1ns/1ps
// Link register access router top: decodes a move request, routes it
// according to level and virtualization controls, and registers a
// one-cycle response. Assumes at most one request per cycle.
module lr_access_router
    import lr_access_pkg::*;
#(
    parameter int                 DATA_W          = 64,
    parameter int                 OFFSET_W        = 12,
    parameter int                 SYND_W          = 6,
    parameter logic [OFFSET_W-1:0] REDIRECT_OFFSET = 12'h230,
    parameter logic [SYND_W-1:0]   TRAP_CLASS      = 6'h18,
    parameter logic [DATA_W-1:0]   POISON          = 64'hDEAD_DEAD_DEAD_DEAD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_op0,
    input  logic [2:0]          req_op1,
    input  logic [3:0]          req_crn,
    input  logic [3:0]          req_crm,
    input  logic [2:0]          req_op2,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [1:0]          cur_level,
    input  logic                lvl2_en,
    input  logic                lvl2_wide,
    input  logic                host_mode,
    input  logic                nest_virt,
    input  logic                nest_el1,
    input  logic                nest_mem,
    input  logic                exc_entry_valid,
    input  logic                exc_entry_sel,
    input  logic [DATA_W-1:0]   exc_entry_addr,
    input  logic                exc_return_l1,
    output logic                rsp_valid,
    output logic [OUTC_W-1:0]   rsp_outcome,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_rdata_known,
    output logic [OFFSET_W-1:0] rsp_mem_offset,
    output logic [SYND_W-1:0]   rsp_syndrome
);

    view_e                          view;
    virt_ctrl_t                     ctrl;
    logic [OUTC_W-1:0]              route;
    logic [NUM_LR-1:0]              sw_we;
    logic [NUM_LR-1:0]              ent_we;
    logic [NUM_LR-1:0]              kill;
    logic [NUM_LR-1:0][DATA_W-1:0]  lr_val;
    logic [NUM_LR-1:0]              lr_known;
    logic [DATA_W-1:0]              rd_data;
    logic                           rd_known;

    // Gather the control inputs into one struct.
    always_comb begin
        ctrl.lvl2_en   = lvl2_en;
        ctrl.lvl2_wide = lvl2_wide;
        ctrl.host_mode = host_mode;
        ctrl.nest_virt = nest_virt;
        ctrl.nest_el1  = nest_el1;
        ctrl.nest_mem  = nest_mem;
    end

    lr_encoding_decode u_decode (
        .op0  (req_op0),
        .op1  (req_op1),
        .crn  (req_crn),
        .crm  (req_crm),
        .op2  (req_op2),
        .view (view)
    );

    lr_route_policy u_policy (
        .level   (level_e'(cur_level)),
        .view    (view),
        .ctrl    (ctrl),
        .outcome (route)
    );

    for (genvar i = 0; i < NUM_LR; i++) begin : g_we
        localparam int OC_BIT = (i == LR_L1) ? OC_REG1 : OC_REG2;
        // Per-register write, entry and invalidate strobes.
        always_comb begin
            sw_we[i]  = req_valid & req_write & route[OC_BIT];
            ent_we[i] = exc_entry_valid & (exc_entry_sel == i[0]);
            kill[i]   = (i == LR_L1) ? exc_return_l1 : 1'b0;
        end
    end

    lr_link_regs #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_LR),
        .POISON   (POISON)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_wdata (req_wdata),
        .ent_we   (ent_we),
        .ent_addr (exc_entry_addr),
        .kill     (kill),
        .val      (lr_val),
        .known    (lr_known)
    );

    // Read mux: the selected register's value, zero for other outcomes.
    always_comb begin
        rd_data  = '0;
        rd_known = 1'b0;
        if (route[OC_REG1]) begin
            rd_data  = lr_val[LR_L1];
            rd_known = lr_known[LR_L1];
        end else if (route[OC_REG2]) begin
            rd_data  = lr_val[LR_L2];
            rd_known = lr_known[LR_L2];
        end
    end

    // Response stage: capture the outcome and sidebands one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_outcome     <= '0;
            rsp_rdata       <= '0;
            rsp_rdata_known <= 1'b0;
            rsp_mem_offset  <= '0;
            rsp_syndrome    <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_outcome     <= req_valid ? route : '0;
            rsp_rdata       <= req_valid ? rd_data : '0;
            rsp_rdata_known <= req_valid & rd_known;
            rsp_mem_offset  <= (req_valid && route[OC_MEM]) ? REDIRECT_OFFSET : '0;
            rsp_syndrome    <= (req_valid && route[OC_TRAP]) ? TRAP_CLASS : '0;
        end
    end

endmodule

// File: rtl/lr_access_router_chk.sv
`timescale 1ns/1ps
// Checker for lr_access_router, bound to every instance of the top.
// Assumes access to the top's internal register array and known flags.
module lr_access_router_chk
    import lr_access_pkg::*;
#(
    parameter int                 DATA_W          = 64,
    parameter int                 OFFSET_W        = 12,
    parameter int                 SYND_W          = 6,
    parameter logic [OFFSET_W-1:0] REDIRECT_OFFSET = 12'h230,
    parameter logic [SYND_W-1:0]   TRAP_CLASS      = 6'h18,
    parameter logic [DATA_W-1:0]   POISON          = 64'hDEAD_DEAD_DEAD_DEAD
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [1:0]                    cur_level,
    input logic                          exc_entry_valid,
    input logic                          exc_entry_sel,
    input logic [DATA_W-1:0]             exc_entry_addr,
    input logic                          exc_return_l1,
    input logic                          rsp_valid,
    input logic [OUTC_W-1:0]             rsp_outcome,
    input logic [DATA_W-1:0]             rsp_rdata,
    input logic [OFFSET_W-1:0]           rsp_mem_offset,
    input logic [SYND_W-1:0]             rsp_syndrome,
    input logic [NUM_LR-1:0][DATA_W-1:0] lr_val,
    input logic [NUM_LR-1:0]             lr_known
);

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_outcome) == 1);

    // R1
    outcome_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_outcome == '0);

    // R3
    level0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level == 2'd0) |=> rsp_outcome[OC_UNDEF]);

    // R9
    nonreg_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_outcome[OC_REG1] && !rsp_outcome[OC_REG2]) |-> rsp_rdata == '0);

    // R10
    redirect_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mem_offset == (rsp_outcome[OC_MEM] ? REDIRECT_OFFSET : '0));

    // R10
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_syndrome == (rsp_outcome[OC_TRAP] ? TRAP_CLASS : '0));

    // R12
    entry_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry_valid && !exc_entry_sel) |=>
            (lr_val[LR_L1] == $past(exc_entry_addr)) && lr_known[LR_L1]);

    // R12
    entry_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry_valid && exc_entry_sel) |=>
            (lr_val[LR_L2] == $past(exc_entry_addr)) && lr_known[LR_L2]);

    // R13
    return_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_l1 && !(exc_entry_valid && !exc_entry_sel)) |=>
            (lr_val[LR_L1] == POISON) && !lr_known[LR_L1]);

endmodule

bind lr_access_router lr_access_router_chk #(
    .DATA_W          (DATA_W),
    .OFFSET_W        (OFFSET_W),
    .SYND_W          (SYND_W),
    .REDIRECT_OFFSET (REDIRECT_OFFSET),
    .TRAP_CLASS      (TRAP_CLASS),
    .POISON          (POISON)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .cur_level       (cur_level),
    .exc_entry_valid (exc_entry_valid),
    .exc_entry_sel   (exc_entry_sel),
    .exc_entry_addr  (exc_entry_addr),
    .exc_return_l1   (exc_return_l1),
    .rsp_valid       (rsp_valid),
    .rsp_outcome     (rsp_outcome),
    .rsp_rdata       (rsp_rdata),
    .rsp_mem_offset  (rsp_mem_offset),
    .rsp_syndrome    (rsp_syndrome),
    .lr_val          (lr_val),
    .lr_known        (lr_known)
);

// File: tb/lr_access_router_bench.sv
`timescale 1ns/1ps
// Bench for lr_access_router: a behavioural reference model updated at each
// rising edge, compared against the outputs at each falling edge.
module lr_access_router_bench;

    localparam logic [4:0]  E_UNDEF = 5'b10000;
    localparam logic [4:0]  E_TRAP  = 5'b01000;
    localparam logic [4:0]  E_MEM   = 5'b00100;
    localparam logic [4:0]  E_REG1  = 5'b00010;
    localparam logic [4:0]  E_REG2  = 5'b00001;
    localparam logic [63:0] E_POISON = 64'hDEAD_DEAD_DEAD_DEAD;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [63:0] req_wdata;
    logic [1:0]  cur_level;
    logic        lvl2_en, lvl2_wide, host_mode, nest_virt, nest_el1, nest_mem;
    logic        exc_entry_valid, exc_entry_sel, exc_return_l1;
    logic [63:0] exc_entry_addr;
    logic        rsp_valid;
    logic [4:0]  rsp_outcome;
    logic [63:0] rsp_rdata;
    logic        rsp_rdata_known;
    logic [11:0] rsp_mem_offset;
    logic [5:0]  rsp_syndrome;

    lr_access_router u_lr_access_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_level(cur_level),
        .lvl2_en(lvl2_en), .lvl2_wide(lvl2_wide), .host_mode(host_mode),
        .nest_virt(nest_virt), .nest_el1(nest_el1), .nest_mem(nest_mem),
        .exc_entry_valid(exc_entry_valid), .exc_entry_sel(exc_entry_sel),
        .exc_entry_addr(exc_entry_addr), .exc_return_l1(exc_return_l1),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_rdata(rsp_rdata),
        .rsp_rdata_known(rsp_rdata_known), .rsp_mem_offset(rsp_mem_offset),
        .rsp_syndrome(rsp_syndrome)
    );

    int checks = 0;
    int errors = 0;
    bit comparing = 0;

    logic [63:0] m_val [2];
    logic        m_known [2];
    string       m_tag [2];

    logic        e_valid;
    logic [4:0]  e_out;
    logic [63:0] e_rdata;
    logic        e_known;
    logic [11:0] e_off;
    logic [5:0]  e_syn;
    string       e_tag;
    string       e_dtag;

    // Expected routing written from the requirement text.
    function automatic void ref_route(
        input logic [1:0] lvl, input logic [1:0] o0, input logic [2:0] o1,
        input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
        input logic en, input logic wide, input logic hm,
        input logic nv, input logic nv1, input logic nv2,
        output logic [4:0] oc, output string tag);
        if (!(o0 == 2'b11 && cn == 4'b0100 && cm == 4'b0000 && o2 == 3'b001) ||
            !(o1 == 3'b000 || o1 == 3'b101 || o1 == 3'b100)) begin
            oc = E_UNDEF; tag = "R2";
        end else if (lvl == 2'd0) begin
            oc = E_UNDEF; tag = "R3";
        end else if (o1 == 3'b000) begin
            if (lvl == 2'd1) begin
                tag = "R4";
                if (en && !nv2 && nv1)                   oc = E_TRAP;
                else if (en && wide && nv2 && nv1 && nv) oc = E_MEM;
                else                                     oc = E_REG1;
            end else begin
                tag = "R5";
                oc = (lvl == 2'd2 && hm) ? E_REG2 : E_REG1;
            end
        end else if (o1 == 3'b101) begin
            if (lvl == 2'd1) begin
                tag = "R6";
                if (en && nv2 && !nv1 && nv) oc = E_MEM;
                else if (en && nv)           oc = E_TRAP;
                else                         oc = E_UNDEF;
            end else begin
                tag = "R7";
                oc = (en && hm) ? E_REG1 : E_UNDEF;
            end
        end else begin
            tag = "R8";
            if (lvl != 2'd1)         oc = E_REG2;
            else if (en && nv2 && nv) oc = E_REG1;
            else if (en && nv)        oc = E_TRAP;
            else                      oc = E_UNDEF;
        end
    endfunction

    // Reference model: compute the next response and register state.
    always @(posedge clk) begin
        logic [4:0] oc;
        string      tag;
        int         idx;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_val[i] = E_POISON; m_known[i] = 1'b0; m_tag[i] = "R11";
            end
            e_valid = 0; e_out = 0; e_rdata = 0; e_known = 0; e_off = 0; e_syn = 0;
            e_tag = "R11"; e_dtag = "R11";
        end else begin
            ref_route(cur_level, req_op0, req_op1, req_crn, req_crm, req_op2,
                      lvl2_en, lvl2_wide, host_mode, nest_virt, nest_el1, nest_mem, oc, tag);
            idx = (oc == E_REG1) ? 0 : (oc == E_REG2) ? 1 : -1;
            e_valid = req_valid;
            e_out   = req_valid ? oc : 5'b0;
            e_tag   = tag;
            e_rdata = (req_valid && idx >= 0) ? m_val[idx] : 64'b0;
            e_known = (req_valid && idx >= 0) ? m_known[idx] : 1'b0;
            e_dtag  = (idx >= 0) ? m_tag[idx] : "R9";
            e_off   = (req_valid && oc == E_MEM) ? 12'h230 : 12'h0;
            e_syn   = (req_valid && oc == E_TRAP) ? 6'h18 : 6'h0;
            if (req_valid && req_write && idx >= 0) begin
                m_val[idx] = req_wdata; m_known[idx] = 1'b1; m_tag[idx] = "R9";
            end
            if (exc_return_l1) begin
                m_val[0] = E_POISON; m_known[0] = 1'b0; m_tag[0] = "R13";
            end
            if (exc_entry_valid) begin
                m_val[exc_entry_sel] = exc_entry_addr;
                m_known[exc_entry_sel] = 1'b1;
                m_tag[exc_entry_sel] = "R12";
            end
        end
    end

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (comparing) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_outcome !== e_out) begin
                errors++;
                $display("FAIL %s R1 valid/outcome actual %b/%b expected %b/%b",
                         e_tag, rsp_valid, rsp_outcome, e_valid, e_out);
            end else if (rsp_rdata !== e_rdata || rsp_rdata_known !== e_known) begin
                errors++;
                $display("FAIL %s data actual %h/%b expected %h/%b",
                         e_dtag, rsp_rdata, rsp_rdata_known, e_rdata, e_known);
            end else if (rsp_mem_offset !== e_off || rsp_syndrome !== e_syn) begin
                errors++;
                $display("FAIL R10 sideband actual %h/%h expected %h/%h",
                         rsp_mem_offset, rsp_syndrome, e_off, e_syn);
            end
        end
    end

    task automatic idle();
        req_valid = 0; req_write = 0; req_op0 = 2'b11; req_op1 = 3'b000;
        req_crn = 4'b0100; req_crm = 4'b0000; req_op2 = 3'b001; req_wdata = '0;
        exc_entry_valid = 0; exc_entry_sel = 0; exc_entry_addr = '0; exc_return_l1 = 0;
    endtask

    // Issue one request for a cycle, then return to idle.
    task automatic access(input logic w, input logic [1:0] lvl,
                          input logic [2:0] o1, input logic [63:0] d);
        req_valid = 1; req_write = w; cur_level = lvl; req_op1 = o1; req_wdata = d;
        @(negedge clk); #1;
        idle();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cur_level = 0;
        lvl2_en = 0; lvl2_wide = 0; host_mode = 0;
        nest_virt = 0; nest_el1 = 0; nest_mem = 0;
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 rsp_valid actual %b expected 0", rsp_valid);
        end
        #1; rst_n = 1;
        comparing = 1;
        // R11: poison and unknown are visible through reads from level 3.
        access(0, 2'd3, 3'b000, '0);
        access(0, 2'd3, 3'b100, '0);
        // R9: software write then read, both registers.
        access(1, 2'd3, 3'b000, 64'h1111_2222_3333_4444);
        access(0, 2'd3, 3'b000, '0);
        access(1, 2'd2, 3'b100, 64'h5555_6666_7777_8888);
        access(0, 2'd2, 3'b100, '0);
        // R5: host mode makes the level-1 view reach the level-2 register.
        host_mode = 1; access(0, 2'd2, 3'b000, '0); host_mode = 0;
        // R12: entry beats a software write to the same register.
        exc_entry_valid = 1; exc_entry_sel = 0; exc_entry_addr = 64'hAAAA_0000_0000_0001;
        access(1, 2'd3, 3'b000, 64'hBAD0);
        access(0, 2'd3, 3'b000, '0);
        // R13: return beats a software write.
        exc_return_l1 = 1;
        access(1, 2'd3, 3'b000, 64'hBAD1);
        access(0, 2'd3, 3'b000, '0);
        // R12: entry beats a same-cycle return.
        exc_return_l1 = 1; exc_entry_valid = 1; exc_entry_sel = 0;
        exc_entry_addr = 64'hCCCC_0000_0000_0002;
        access(0, 2'd3, 3'b000, '0);
        access(0, 2'd3, 3'b000, '0);
        // R4: redirect and trap from level 1.
        lvl2_en = 1; lvl2_wide = 1; nest_virt = 1; nest_el1 = 1; nest_mem = 1;
        access(0, 2'd1, 3'b000, '0);
        nest_mem = 0; access(1, 2'd1, 3'b000, 64'hBAD2);
        // R6, R8: alias and level-2 views from level 1.
        nest_mem = 1; nest_el1 = 0; access(0, 2'd1, 3'b101, '0);
        access(0, 2'd1, 3'b100, '0);
        // R2, R3: bad encoding and level 0.
        req_crm = 4'b0001; access(0, 2'd3, 3'b000, '0);
        access(0, 2'd0, 3'b100, '0);
        // Random sweep over levels, views, controls and side events.
        for (int n = 0; n < 4000; n++) begin
            int sel;
            req_valid = ($urandom % 4) != 0;
            req_write = $urandom % 2;
            sel = $urandom % 10;
            req_op1 = (sel < 3) ? 3'b000 : (sel < 6) ? 3'b101 : (sel < 9) ? 3'b100 : 3'($urandom);
            if (($urandom % 12) == 0) begin
                req_op0 = 2'($urandom); req_crn = 4'($urandom);
                req_crm = 4'($urandom); req_op2 = 3'($urandom);
            end else begin
                req_op0 = 2'b11; req_crn = 4'b0100; req_crm = 4'b0000; req_op2 = 3'b001;
            end
            req_wdata = {$urandom, $urandom};
            cur_level = 2'($urandom);
            {lvl2_en, lvl2_wide, host_mode, nest_virt, nest_el1, nest_mem} = 6'($urandom);
            exc_entry_valid = ($urandom % 8) == 0;
            exc_entry_sel = $urandom % 2;
            exc_entry_addr = {$urandom, $urandom};
            exc_return_l1 = ($urandom % 8) == 0;
            @(negedge clk); #1;
        end
        idle();
        repeat (2) @(negedge clk);
        comparing = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule